// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the four threshold offsets that a pair of opposite-direction FIFOs uses for their almost-empty and almost-full flags. Each FIFO has one offset for the almost-full side (X1, X2) and one for the almost-empty side (Y1, Y2). Every register is `OFS_W` bits wide. The block does not compare these offsets against fill levels. It only fills them and reports when they are ready.

The filling method is chosen once, on the clock A edge where the FIFO1 master reset input is sampled high after having been low. At that edge a 3-bit select is latched. The select picks one of three methods:

- **Preset:** one of five fixed values is applied to all four registers.
- **Parallel:** four writes on a wide data port fill the registers.
- **Serial:** the four registers are shifted in one bit per clock, as a single chain.

After the end of reset the same select pins change role. `fsel[1]` becomes an active-low serial enable and `fsel[0]` becomes the serial data bit. When the FIFO2 master reset ends on its own, only the FIFO2 offsets are cleared. The method and the `done` state are kept.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrs1_n` is low, `done` is low one clock later and stays low, and no loading takes place.
- R2: The edge where `mrs1_n` is first sampled high latches `fsel` as the method code: 001 is serial, 010..110 are presets, and any other code is parallel.
- R3: The preset codes map as follows: 010 gives 8, 011 gives 16, 100 gives 64, 101 gives 256 and 110 gives 1024. All four registers take the value on the ending edge, and `done` rises one clock later.
- R4: In serial mode, every clock with `fsel[1]` low shifts `fsel[0]` into a chain ordered Y1, X1, Y2, X2, with each register MSB first. The first bit ends up as the MSB of Y1 and the last bit as the LSB of X2. Clocks with `fsel[1]` high shift nothing.
- R5: Serial loading completes after exactly 4*`OFS_W` enabled bits (52 with the default width). `done` is high on the clock that takes the last bit.
- R6: Once `done` is high, further serial bits and parallel writes leave all four registers unchanged.
- R7: In parallel mode, successive clocks with `wr_a` high load Y1, X1, Y2 and X2 in that order from `din_a[OFS_W-1:0]`. Upper data bits are ignored, and `done` rises with the fourth write.
- R8: Codes 000 and 111 both select parallel mode.
- R9: When `mrs2_n` rises while `mrs1_n` stays high, X2 and Y2 are cleared to zero, while X1, Y1 and `done` keep their values.
- R10: When both resets rise on the same clock, the method is latched as in R2. With a non-preset code, X2 and Y2 are also cleared on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock; all state changes on its rising edge |
| mrs1_n | input | 1 | FIFO1 master reset, active low, sampled on clk_a |
| mrs2_n | input | 1 | FIFO2 master reset, active low, sampled on clk_a |
| fsel | input | 3 | Method select at reset end; afterwards bit 1 is the serial enable (active low) and bit 0 the serial data |
| wr_a | input | 1 | Parallel write strobe |
| din_a | input | DATA_W | Parallel write data; the low OFS_W bits are used |
| x1 | output | OFS_W | FIFO1 almost-full offset |
| y1 | output | OFS_W | FIFO1 almost-empty offset |
| x2 | output | OFS_W | FIFO2 almost-full offset |
| y2 | output | OFS_W | FIFO2 almost-empty offset |
| done | output | 1 | Offsets are fully loaded |

## Verification
The bench checks the serial chain order by shifting in a 52-bit pattern in which every register has a distinct value. A reversed chain, or registers shifted LSB first, would put visibly wrong values on all four outputs.

It counts bits with enable gaps inserted and then sends extra bits after completion. A design that is off by one in its bit count, or that keeps shifting after `done`, would either raise `done` one bit early or late, or corrupt the loaded values.

Every preset code is exercised, and both reserved-as-parallel codes are exercised. Parallel writes carry set upper bits, so a wrong write order or a wrong data slice shows up directly on the outputs.

The FIFO2-only reset is checked to clear just X2 and Y2. The simultaneous reset release is checked to clear X2 and Y2 before a new serial load, so a design that mixes up the two reset edges would fail.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int OFS_W  = 13,
  parameter int DATA_W = 36
) (
  input  logic              clk_a,
  input  logic              mrs1_n,
  input  logic              mrs2_n,
  input  logic [2:0]        fsel,
  input  logic              wr_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [OFS_W-1:0]  x1,
  output logic [OFS_W-1:0]  y1,
  output logic [OFS_W-1:0]  x2,
  output logic [OFS_W-1:0]  y2,
  output logic              done
);
  localparam int CHAIN_W = 4 * OFS_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);
  localparam int HALF_W  = 2 * OFS_W;

  typedef enum logic [1:0] {M_IDLE, M_PAR, M_SER, M_PRE} mode_t;

  mode_t              mode;
  logic               mrs1_q, mrs2_q;
  logic [CNT_W-1:0]   cnt;
  logic [CHAIN_W-1:0] chain;
  logic [OFS_W-1:0]   pval;

  wire end1     = mrs1_n & ~mrs1_q;
  wire end2     = mrs2_n & ~mrs2_q;
  wire shift_en = (mode == M_SER) && !fsel[1] && !done;
  wire par_en   = (mode == M_PAR) && wr_a && !done;
  wire last_bit = (cnt == CNT_W'(CHAIN_W - 1));
  wire [OFS_W-1:0] wdata = din_a[OFS_W-1:0];
  wire unused_din_hi = ^din_a[DATA_W-1:OFS_W];

  assign {y1, x1, y2, x2} = chain;

  always_comb begin
    case (fsel)
      3'b010:  pval = OFS_W'(8);
      3'b011:  pval = OFS_W'(16);
      3'b100:  pval = OFS_W'(64);
      3'b101:  pval = OFS_W'(256);
      3'b110:  pval = OFS_W'(1024);
      default: pval = '0;
    endcase
  end

  always_ff @(posedge clk_a) begin
    mrs1_q <= mrs1_n;
    mrs2_q <= mrs2_n;
    if (!mrs1_n) begin
      mode <= M_IDLE;
      done <= 1'b0;
      cnt  <= '0;
    end else if (end1) begin
      done <= 1'b0;
      cnt  <= '0;
      case (fsel)
        3'b001: begin
          mode <= M_SER;
          if (end2) chain[HALF_W-1:0] <= '0;
        end
        3'b010, 3'b011, 3'b100, 3'b101, 3'b110: begin
          mode  <= M_PRE;
          chain <= {4{pval}};
        end
        default: begin
          mode <= M_PAR;
          if (end2) chain[HALF_W-1:0] <= '0;
        end
      endcase
    end else if (end2) begin
      chain[HALF_W-1:0] <= '0;
    end else if (mode == M_PRE) begin
      done <= 1'b1;
    end else if (shift_en) begin
      chain <= {chain[CHAIN_W-2:0], fsel[0]};
      cnt   <= cnt + 1'b1;
      if (last_bit) done <= 1'b1;
    end else if (par_en) begin
      case (cnt[1:0])
        2'd0: chain[4*OFS_W-1 -: OFS_W] <= wdata;
        2'd1: chain[3*OFS_W-1 -: OFS_W] <= wdata;
        2'd2: chain[2*OFS_W-1 -: OFS_W] <= wdata;
        default: chain[OFS_W-1 -: OFS_W] <= wdata;
      endcase
      cnt <= cnt + 1'b1;
      if (cnt[1:0] == 2'd3) done <= 1'b1;
    end
  end
endmodule

module flag_offset_loader_chk #(
  parameter int OFS_W = 13
) (
  input logic             clk_a,
  input logic             mrs1_n,
  input logic             mrs2_n,
  input logic [2:0]       fsel,
  input logic [OFS_W-1:0] x1,
  input logic [OFS_W-1:0] y1,
  input logic [OFS_W-1:0] x2,
  input logic [OFS_W-1:0] y2,
  input logic             done
);
  logic armed = 1'b0;
  always_ff @(posedge clk_a) armed <= 1'b1;

  a_r1_done_low_in_reset: assert property (@(posedge clk_a) disable iff (!armed)
    !mrs1_n |=> !done);

  a_r5_done_needs_reset_high: assert property (@(posedge clk_a) disable iff (!armed)
    $rose(done) |-> $past(mrs1_n));

  a_r6_hold_after_done: assert property (@(posedge clk_a) disable iff (!armed)
    (done && mrs1_n && mrs2_n && $past(mrs2_n)) |=> ($stable({y1, x1, y2, x2}) && done));

  a_r3_preset_all_equal: assert property (@(posedge clk_a) disable iff (!armed)
    (mrs1_n && !$past(mrs1_n) && fsel >= 3'b010 && fsel <= 3'b110)
      |=> (!done && y1 == x1 && x1 == y2 && y2 == x2));

  a_r9_fifo2_clear: assert property (@(posedge clk_a) disable iff (!armed)
    (mrs1_n && $past(mrs1_n) && mrs2_n && !$past(mrs2_n))
      |=> (x2 == '0 && y2 == '0 && $stable({y1, x1})));
endmodule

bind flag_offset_loader flag_offset_loader_chk #(.OFS_W(OFS_W)) u_chk (
  .clk_a(clk_a), .mrs1_n(mrs1_n), .mrs2_n(mrs2_n), .fsel(fsel),
  .x1(x1), .y1(y1), .x2(x2), .y2(y2), .done(done)
);

// File: tb/flag_offset_loader_test.sv
module flag_offset_loader_test;
  localparam int W  = 13;
  localparam int DW = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          mrs1_n = 1'b0, mrs2_n = 1'b0, wr_a = 1'b0;
  logic [2:0]    fsel = 3'b000;
  logic [DW-1:0] din_a = '0;
  logic [W-1:0]  x1, y1, x2, y2;
  logic          done;

  flag_offset_loader #(.OFS_W(W), .DATA_W(DW)) uut (
    .clk_a(clk), .mrs1_n(mrs1_n), .mrs2_n(mrs2_n), .fsel(fsel), .wr_a(wr_a),
    .din_a(din_a), .x1(x1), .y1(y1), .x2(x2), .y2(y2), .done(done));

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";

  // reference model: mm 0 idle, 1 parallel, 2 serial, 3 preset; ev 0=y1 1=x1 2=y2 3=x2
  int mm = 0, mc = 0;
  bit md = 0, p1 = 0, p2 = 0;
  bit bits[$];
  logic [W-1:0] ev [4];

  function automatic logic [W-1:0] preset_val(input logic [2:0] c);
    case (c)
      3'b010: return W'(8);
      3'b011: return W'(16);
      3'b100: return W'(64);
      3'b101: return W'(256);
      default: return W'(1024);
    endcase
  endfunction

  always @(posedge clk) begin
    bit r1, r2;
    r1 = mrs1_n && !p1;
    r2 = mrs2_n && !p2;
    p1 = mrs1_n;
    p2 = mrs2_n;
    if (!mrs1_n) begin
      mm = 0; md = 0; mc = 0; bits.delete();
    end else if (r1) begin
      md = 0; mc = 0; bits.delete();
      if (fsel == 3'b001) mm = 2;
      else if (fsel >= 3'b010 && fsel <= 3'b110) begin
        mm = 3;
        for (int i = 0; i < 4; i++) ev[i] = preset_val(fsel);
      end else mm = 1;
      if (r2 && mm != 3) begin ev[2] = '0; ev[3] = '0; end
    end else if (r2) begin
      ev[2] = '0; ev[3] = '0;
    end else if (!md) begin
      if (mm == 3) md = 1;
      else if (mm == 2 && !fsel[1]) begin
        bits.push_back(fsel[0]);
        if (bits.size() == 4 * W) begin
          for (int r = 0; r < 4; r++)
            for (int b = 0; b < W; b++) ev[r][W-1-b] = bits[r*W+b];
          md = 1;
        end
      end else if (mm == 1 && wr_a) begin
        ev[mc] = din_a[W-1:0];
        mc++;
        if (mc == 4) md = 1;
      end
    end
  end

  task automatic chk(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    chk("done", W'(done), W'(md));
    if (md) begin
      chk("y1", y1, ev[0]);
      chk("x1", x1, ev[1]);
      chk("y2", y2, ev[2]);
      chk("x2", x2, ev[3]);
    end
  endtask

  task automatic mreset(input logic [2:0] code, input bit both);
    mrs1_n = 1'b0;
    if (both) mrs2_n = 1'b0;
    fsel = code;
    wr_a = 1'b0;
    repeat (4) tick();
    mrs1_n = 1'b1;
    mrs2_n = 1'b1;
    tick();
    fsel = 3'b010;
  endtask

  task automatic sbit(input bit b);
    fsel = {1'b0, 1'b0, b};
    tick();
    fsel = 3'b010;
  endtask

  task automatic pwrite(input logic [DW-1:0] d);
    wr_a = 1'b1;
    din_a = d;
    tick();
    wr_a = 1'b0;
  endtask

  task automatic serial_load(input logic [4*W-1:0] pat);
    for (int i = 4 * W - 1; i >= 0; i--) begin
      sbit(pat[i]);
      if (i % 5 == 0) tick();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    tag = "R1";
    repeat (4) tick();
    chk("done in reset", W'(done), W'(0));

    tag = "R3";
    for (int c = 2; c <= 6; c++) begin
      mreset(3'(c), 1'b1);
      chk("done one cycle after reset end", W'(done), W'(0));
      tick();
      chk("preset y1", y1, preset_val(3'(c)));
      repeat (2) tick();
    end

    tag = "R4";
    mreset(3'b001, 1'b1);
    serial_load({13'h1ABC, 13'h0123, 13'h1F0F, 13'h0A55});
    chk("serial y1", y1, 13'h1ABC);
    chk("serial x2", x2, 13'h0A55);
    tag = "R5";
    chk("done after 52 bits", W'(done), W'(1));
    tag = "R6";
    for (int i = 0; i < 6; i++) sbit(i[0]);
    pwrite('1);
    chk("x1 held", x1, 13'h0123);

    tag = "R9";
    mrs2_n = 1'b0;
    repeat (3) tick();
    mrs2_n = 1'b1;
    tick();
    tick();
    chk("x2 cleared", x2, '0);
    chk("y1 kept", y1, 13'h1ABC);

    tag = "R7";
    mreset(3'b000, 1'b0);
    pwrite(36'hF_0000_1111);
    tick();
    pwrite(36'hF_0000_0222);
    pwrite(36'h8_0000_1333);
    tick();
    tick();
    chk("done before 4th write", W'(done), W'(0));
    pwrite(36'hA_0000_0444);
    chk("par y1", y1, 13'h1111);
    chk("par x2", x2, 13'h0444);
    tag = "R6";
    pwrite(36'h0_0000_0777);
    chk("par x2 held", x2, 13'h0444);

    tag = "R8";
    mreset(3'b111, 1'b0);
    pwrite(36'h1);
    pwrite(36'h2);
    pwrite(36'h3);
    pwrite(36'h4);
    chk("code 111 parallel x1", x1, 13'h0002);

    tag = "R2";
    mreset(3'b001, 1'b0);
    for (int i = 0; i < 4; i++) pwrite(36'h5);
    chk("serial mode ignores writes", W'(done), W'(0));

    tag = "R10";
    mreset(3'b001, 1'b1);
    chk("both ends clear y2", y2, '0);
    serial_load({13'h0001, 13'h1000, 13'h0F0F, 13'h1234});
    chk("serial reload x2", x2, 13'h1234);
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule